// File: doc/BRIEF.md
# Byte-Wide Down-Counting Timer with Capture

This block is an 8-bit synchronous down counter that sits on a simple byte-wide register bus. Software programs a reload value, a compare value and three control bits, then enables the timer. The count falls by one on every clock and reloads from the period value after it reaches zero. The block drives three outputs: a terminal-count pulse, a compare level and an interrupt that follows one of the two.

Software does not read the live count directly. A read of the count address returns zero and copies the count into the capture/compare register, where software can then read it. A rising edge on the hardware capture input also takes a snapshot. While that input is high, software snapshots are blocked. A capture-propagate output and input let a neighbouring block of a wider timer capture in the same cycle. A period of zero selects a divide-by-one mode, in which the terminal-count and interrupt outputs both become the inverted clock.

Register addresses: 0 = count, 1 = period (write-only), 2 = capture/compare, 3 = control. Control bit 0 = enable, bit 1 = interrupt source (0 terminal count, 1 compare), bit 2 = compare type (0 less-than, 1 less-or-equal).

Top module: `dtimer8`

## Requirements
- R1: After reset, the count, period, capture/compare and control registers are all zero and the timer is disabled. Reads of addresses 2 and 3 return 00h, and the terminal-count and interrupt outputs are low.
- R2: While control bit 0 is set, the count decrements by one on each clock. At zero it reloads from the period register on the next clock. The terminal-count output is high for exactly the cycles in which the enabled count equals zero, provided the period is non-zero.
- R3: While disabled, a write to address 1 loads the period and the count with the same byte in the same cycle. While enabled, such a write changes only the period. A write to address 0 has no effect.
- R4: A read of address 0 returns 00h on the data bus and, while the hardware capture input is low, copies the current count into the capture/compare register at that clock edge.
- R5: A rising edge on the hardware capture input, meaning the input is high this cycle and was low the cycle before, copies the current count into the capture/compare register at that clock edge.
- R6: While the hardware capture input is high, software capture requests are ignored. This covers both reads of address 0 and the capture-propagate input.
- R7: With a period of 00h and the timer enabled, the terminal-count and interrupt outputs both equal the inverted clock.
- R8: With control bit 1 clear, the interrupt output follows the terminal-count output. With control bit 1 set, it follows the compare output. Both apply only while the timer is enabled and the period is non-zero.
- R9: The compare output is a level that is valid in every cycle. With control bit 2 clear it is count < compare; with control bit 2 set it is count <= compare. Address 2 is readable and writable by software.
- R10: The capture-propagate output is high in any cycle in which a software capture takes effect. A high capture-propagate input, with the hardware capture input low, causes a capture exactly as a read of address 0 does.
- R11: A read of address 1 returns 00h. A read of address 3 returns the three control bits in bits 2:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| cap_hw | input | 1 | Hardware capture request |
| cap_chain_in | input | 1 | Capture request from a lower-byte block |
| cap_chain_out | output | 1 | Software capture taking effect in this block |
| tc_out | output | 1 | Terminal-count output |
| cmp_out | output | 1 | Compare output level |
| irq_out | output | 1 | Interrupt output |

## Verification
The assertions assume that all inputs are synchronous to the clock and that the count reload uses the period value held before the edge. They also assume that a capture-register write never coincides with a capture in the cases they check, so those cases exclude bus writes in the same cycle. The stimulus changes every input only on the falling clock edge and issues at most one bus operation per cycle. It holds the hardware capture input steady for whole cycles, so every snapshot and mask decision falls on a single, well-defined rising edge.

// File: rtl/dtimer8.sv
module dtimer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         cap_hw,
  input  logic         cap_chain_in,
  output logic         cap_chain_out,
  output logic         tc_out,
  output logic         cmp_out,
  output logic         irq_out
);
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_PER = 2'd1;
  localparam logic [1:0] A_CMP = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic [W-1:0] cnt, per, cmpv;
  logic [2:0]   ctl;
  logic         hw_q;

  wire en      = ctl[0];
  wire irq_cmp = ctl[1];
  wire le_mode = ctl[2];
  wire wr_per  = wr_en && addr == A_PER;
  wire rd_cnt  = rd_en && addr == A_CNT;
  wire sw_cap  = (rd_cnt || cap_chain_in) && !cap_hw;
  wire hw_edge = cap_hw && !hw_q;
  wire div1    = per == '0;
  wire at_zero = cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      per  <= '0;
      cmpv <= '0;
      ctl  <= '0;
      hw_q <= 1'b0;
    end else begin
      hw_q <= cap_hw;
      if (wr_per) per <= wdata;
      if (wr_en && addr == A_CTL) ctl <= wdata[2:0];
      if (en) cnt <= at_zero ? per : cnt - 1'b1;
      else if (wr_per) cnt <= wdata;
      if (hw_edge || sw_cap) cmpv <= cnt;
      else if (wr_en && addr == A_CMP) cmpv <= wdata;
    end
  end

  assign cap_chain_out = sw_cap;
  assign cmp_out = le_mode ? (cnt <= cmpv) : (cnt < cmpv);
  assign tc_out  = en && (div1 ? ~clk : at_zero);
  assign irq_out = en && (div1 ? ~clk : (irq_cmp ? cmp_out : at_zero));

  always_comb begin
    case (addr)
      A_CMP:   rdata = cmpv;
      A_CTL:   rdata = {{(W-3){1'b0}}, ctl};
      default: rdata = '0;
    endcase
  end

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && !at_zero |=> cnt == $past(cnt) - 1'b1);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && at_zero |=> cnt == $past(per));
  assert_period_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en && wr_per |=> cnt == $past(wdata));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_per |=> $stable(cnt));
  assert_sw_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt && !cap_hw && !wr_en |=> cmpv == $past(cnt));
  assert_count_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt |-> rdata == '0);
  assert_hw_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hw && !hw_q |=> cmpv == $past(cnt));
  assert_sw_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hw && hw_q && !wr_en |=> $stable(cmpv));
  assert_div1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && div1 && at_zero |=> cnt == '0);
endmodule

// File: tb/dtimer8_test.sv
`timescale 1ns/1ps
module dtimer8_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic cap_hw = 1'b0, cap_chain_in = 1'b0;
  logic cap_chain_out, tc_out, cmp_out, irq_out;

  int total = 0, bad = 0;
  string tag = "R1";
  logic [7:0] last_rd;
  logic [7:0] m_cnt = 0, m_per = 0, m_cmp = 0;
  logic [2:0] m_ctl = 0;
  logic m_hwq = 0;

  always #2.5 clk = ~clk;

  dtimer8 #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_hw(cap_hw), .cap_chain_in(cap_chain_in),
    .cap_chain_out(cap_chain_out), .tc_out(tc_out), .cmp_out(cmp_out), .irq_out(irq_out));

  // table row: {req[3:0], wr, rd, addr[1:0], data[7:0], expected read[7:0]}
  localparam int NV = 15;
  localparam logic [23:0] TBL [NV] = '{
    {4'd3, 1'b1, 1'b0, 2'd1, 8'h37, 8'h00},  // R3 period write loads count
    {4'd4, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00},  // R4 count read returns zero
    {4'd4, 1'b0, 1'b1, 2'd2, 8'h00, 8'h37},  // R4 captured count visible
    {4'd9, 1'b1, 1'b0, 2'd2, 8'h10, 8'h00},  // R9 compare write
    {4'd9, 1'b0, 1'b1, 2'd2, 8'h00, 8'h10},  // R9 compare readback
    {4'd11, 1'b0, 1'b1, 2'd1, 8'h00, 8'h00}, // R11 period is write-only
    {4'd11, 1'b1, 1'b0, 2'd3, 8'hFE, 8'h00}, // R11 control write
    {4'd11, 1'b0, 1'b1, 2'd3, 8'h00, 8'h06}, // R11 control readback
    {4'd11, 1'b1, 1'b0, 2'd3, 8'h00, 8'h00},
    {4'd3, 1'b1, 1'b0, 2'd1, 8'h05, 8'h00},
    {4'd4, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00},
    {4'd3, 1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R3 reload of new period
    {4'd3, 1'b1, 1'b0, 2'd0, 8'h99, 8'h00},  // R3 count write ignored
    {4'd4, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00},
    {4'd3, 1'b0, 1'b1, 2'd2, 8'h00, 8'h05}
  };

  task automatic chk(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic logic e_cmp();
    return m_ctl[2] ? (m_cnt <= m_cmp) : (m_cnt < m_cmp);
  endfunction
  function automatic logic e_tc(input logic ck);
    return m_ctl[0] && ((m_per == 0) ? !ck : (m_cnt == 0));
  endfunction
  function automatic logic e_irq(input logic ck);
    return m_ctl[0] && ((m_per == 0) ? !ck : (m_ctl[1] ? e_cmp() : (m_cnt == 0)));
  endfunction

  task automatic chk_outs(input logic ck);
    chk(tag, "tc_out", {7'd0, tc_out}, {7'd0, e_tc(ck)});
    chk(tag, "cmp_out", {7'd0, cmp_out}, {7'd0, e_cmp()});
    chk(tag, "irq_out", {7'd0, irq_out}, {7'd0, e_irq(ck)});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    logic sw, hwe;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #2;
    last_rd = rdata;
    sw = ((r && a == 2'd0) || cap_chain_in) && !cap_hw;
    chk("R10", "cap_chain_out", {7'd0, cap_chain_out}, {7'd0, sw});
    chk_outs(1'b0);
    @(posedge clk);
    hwe = cap_hw && !m_hwq;
    if (hwe || sw) m_cmp = m_cnt;
    else if (w && a == 2'd2) m_cmp = d;
    if (m_ctl[0]) m_cnt = (m_cnt == 0) ? m_per : m_cnt - 8'd1;
    else if (w && a == 2'd1) m_cnt = d;
    if (w && a == 2'd1) m_per = d;
    if (w && a == 2'd3) m_ctl = d[2:0];
    m_hwq = cap_hw;
    #1;
    chk_outs(1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic rd_cmp(input string t);
    logic [7:0] e;
    e = m_cmp;
    cyc(1'b0, 1'b1, 2'd2, 8'd0);
    chk(t, "capture/compare read", last_rd, e);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    #1;
    chk("R1", "tc_out", {7'd0, tc_out}, 8'd0);
    chk("R1", "irq_out", {7'd0, irq_out}, 8'd0);
    cyc(1'b0, 1'b1, 2'd2, 8'd0); chk("R1", "compare reg", last_rd, 8'h00);
    cyc(1'b0, 1'b1, 2'd3, 8'd0); chk("R1", "control reg", last_rd, 8'h00);

    // vector table, timer disabled
    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d", TBL[v][23:20]);
      cyc(TBL[v][19], TBL[v][18], TBL[v][17:16], TBL[v][15:8]);
      if (TBL[v][18]) chk(tag, "table read", last_rd, TBL[v][7:0]);
    end

    // R2 counting and reload, terminal count pulse, interrupt on terminal count
    tag = "R2";
    cyc(1'b1, 1'b0, 2'd1, 8'd3);
    cyc(1'b1, 1'b0, 2'd2, 8'd2);
    cyc(1'b1, 1'b0, 2'd3, 8'd1);
    idle(10);
    // R3 period write while enabled leaves count running
    tag = "R3";
    cyc(1'b1, 1'b0, 2'd1, 8'd6);
    idle(3);
    cyc(1'b0, 1'b1, 2'd0, 8'd0);
    chk("R4", "count read", last_rd, 8'h00);
    rd_cmp("R3");
    idle(8);

    // R9 compare types, R8 interrupt from compare
    tag = "R9";
    cyc(1'b1, 1'b0, 2'd2, 8'd3);
    cyc(1'b1, 1'b0, 2'd3, 8'd1);
    idle(7);
    cyc(1'b1, 1'b0, 2'd3, 8'd5);
    idle(7);
    tag = "R8";
    cyc(1'b1, 1'b0, 2'd3, 8'd7);
    idle(7);
    cyc(1'b1, 1'b0, 2'd3, 8'd3);
    idle(7);

    // R5 hardware capture on rising edge
    tag = "R5";
    idle(2);
    cap_hw = 1'b1;
    idle(1);
    cap_hw = 1'b0;
    idle(2);
    rd_cmp("R5");
    // R6 software capture masked while hardware input high
    tag = "R6";
    cap_hw = 1'b1;
    idle(3);
    cyc(1'b0, 1'b1, 2'd0, 8'd0);
    chk("R6", "count read", last_rd, 8'h00);
    cap_chain_in = 1'b1;
    idle(2);
    cap_chain_in = 1'b0;
    rd_cmp("R6");
    cap_hw = 1'b0;
    idle(1);

    // R10 capture-propagate input and output
    tag = "R10";
    idle(3);
    cap_chain_in = 1'b1;
    idle(1);
    cap_chain_in = 1'b0;
    idle(2);
    rd_cmp("R10");
    cyc(1'b0, 1'b1, 2'd0, 8'd0);
    rd_cmp("R10");

    // R7 divide-by-one mode
    tag = "R7";
    cyc(1'b1, 1'b0, 2'd3, 8'd0);
    cyc(1'b1, 1'b0, 2'd1, 8'd0);
    cyc(1'b1, 1'b0, 2'd3, 8'd1);
    idle(6);
    cyc(1'b1, 1'b0, 2'd3, 8'd3);
    idle(4);
    cyc(1'b1, 1'b0, 2'd3, 8'd0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule